// File: doc/BRIEF.md
# AXI4-to-AXI3 Write Burst Splitter

This block sits between an AXI4 write master and an AXI3 write slave. It accepts AXI4 write bursts of up to 256 beats on its upstream side and issues them downstream as a sequence of AXI3 bursts of at most 16 beats each. For every downstream piece after the first, the address moves forward by one full piece. Write data passes straight through. The block supplies the AXI3 write ID, which AXI4 does not carry, and places WLAST at the end of every piece.

The downstream write responses for all pieces of one upstream burst are merged into a single upstream response. That response carries the most severe status seen among the pieces. Two small queues pass burst information from the address engine to the data path and to the response path, so those three paths run independently of one another. Because the merge relies on downstream responses arriving in issue order, a new upstream burst whose ID differs from the bursts still awaiting their response is held back until all of those responses have been returned.

Top module: `axi_wr_burst_split`

## Requirements
- R1: An upstream burst with AWLEN = L (0..255) is issued downstream as (L >> 4) + 1 bursts, in order. Every piece except the last has AWLEN 15 and the last has AWLEN L[3:0]. All pieces carry the upstream ID, AWSIZE and AWBURST.
- R2: For INCR bursts (AWBURST = 2'b01), piece p goes to the upstream address plus p * 16 * 2^AWSIZE.
- R3: Once the downstream AWVALID is raised, it stays high, with address, length and ID unchanged, until AWREADY is seen.
- R4: Downstream write beats carry the upstream data and strobes unchanged. WID equals the ID of the burst the beat belongs to, and bursts are taken in the order their addresses were accepted.
- R5: Downstream WLAST is high on beat 16 of every piece and on the final beat of the burst, and on no other beat. Upstream WLAST must coincide with the final beat of the burst.
- R6: Each upstream burst receives exactly one upstream write response, in acceptance order, with BID equal to its ID. The response is raised only after the downstream responses of all its pieces have been taken.
- R7: The upstream BRESP is the most severe of the burst's downstream BRESP values, ranked DECERR (2'b11) above SLVERR (2'b10) above OKAY (2'b00). EXOKAY (2'b01) counts as OKAY, and each burst's merge starts from OKAY.
- R8: A raised upstream BVALID stays high, with BID and BRESP unchanged, until BREADY is seen.
- R9: The upstream AWREADY stays low while any accepted burst is still awaiting its upstream response and the offered AWID differs from that burst's ID.
- R10: Queues of QUEUE_DEPTH entries decouple the three paths. Write beats of a later burst can be taken before an earlier burst's response has been returned, and neither queue is pushed when full or popped when empty.
- R11: While reset is held, the downstream AWVALID and the upstream BVALID are low, and no write beat is accepted.
- R12: Each downstream response taken carries the ID of the burst at the head of the response queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_awvalid | input | 1 | Upstream address valid |
| up_awready | output | 1 | Upstream address ready |
| up_awid | input | ID_W | Upstream burst ID |
| up_awaddr | input | ADDR_W | Upstream start address |
| up_awlen | input | 8 | Upstream burst length minus one |
| up_awsize | input | 3 | Beat size code |
| up_awburst | input | 2 | Burst type |
| up_wvalid | input | 1 | Upstream write beat valid |
| up_wready | output | 1 | Upstream write beat ready |
| up_wdata | input | DATA_W | Upstream write data |
| up_wstrb | input | DATA_W/8 | Upstream byte strobes |
| up_wlast | input | 1 | Upstream last beat of burst |
| up_bvalid | output | 1 | Upstream response valid |
| up_bready | input | 1 | Upstream response ready |
| up_bid | output | ID_W | Upstream response ID |
| up_bresp | output | 2 | Merged response status |
| dn_awvalid | output | 1 | Downstream address valid |
| dn_awready | input | 1 | Downstream address ready |
| dn_awid | output | ID_W | Downstream burst ID |
| dn_awaddr | output | ADDR_W | Downstream piece address |
| dn_awlen | output | 4 | Downstream piece length minus one |
| dn_awsize | output | 3 | Beat size code |
| dn_awburst | output | 2 | Burst type |
| dn_wvalid | output | 1 | Downstream write beat valid |
| dn_wready | input | 1 | Downstream write beat ready |
| dn_wid | output | ID_W | Downstream write ID |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_wstrb | output | DATA_W/8 | Downstream byte strobes |
| dn_wlast | output | 1 | Downstream last beat of piece |
| dn_bvalid | input | 1 | Downstream response valid |
| dn_bready | output | 1 | Downstream response ready |
| dn_bid | input | ID_W | Downstream response ID |
| dn_bresp | input | 2 | Downstream response status |

## Verification
The assertions check on every cycle the properties that depend only on local state. These are the hold rules for the downstream address and upstream response channels, the agreement of upstream WLAST with the beat counter, the match of each downstream response ID with the queue head, queue overflow and underflow, and the absence of any upstream response without an outstanding burst. Piece count and lengths, piece addresses, WID and WLAST placement, the merged status, ID throttling and the data path running ahead of responses involve whole bursts. Only the bench's scenarios can show those: a sweep over every length from 1 to 256 beats and several beat sizes, with error and exclusive-okay statuses injected at arithmetic positions, first with all channels ready and then with staggered back-pressure on every channel.

// File: rtl/axi_split_pkg.sv
package axi_split_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  localparam logic [1:0] BURST_INCR  = 2'b01;

  localparam int PIECE_BEATS = 16;

  // Severity rank: decode error highest, slave error next, both okays lowest
  function automatic logic [1:0] resp_rank(input logic [1:0] r);
    case (r)
      RESP_DECERR: return 2'd2;
      RESP_SLVERR: return 2'd1;
      default:     return 2'd0;
    endcase
  endfunction

  // Keep the more severe status; on a tie keep the running value
  function automatic logic [1:0] resp_worse(input logic [1:0] acc, input logic [1:0] nxt);
    return (resp_rank(nxt) > resp_rank(acc)) ? nxt : acc;
  endfunction

endpackage

// File: rtl/axi_split_fifo.sv
module axi_split_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push;
  logic             do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // Storage without reset so it maps onto distributed or block memory
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

  // R10: producers and consumers respect the queue limits
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/axi_split_aw.sv
module axi_split_aw
  import axi_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int OUT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_awvalid,
  output logic              up_awready,
  input  logic [ID_W-1:0]   up_awid,
  input  logic [ADDR_W-1:0] up_awaddr,
  input  logic [7:0]        up_awlen,
  input  logic [2:0]        up_awsize,
  input  logic [1:0]        up_awburst,
  input  logic              q_full,
  output logic              q_push,
  input  logic              resp_done,
  output logic              dn_awvalid,
  input  logic              dn_awready,
  output logic [ID_W-1:0]   dn_awid,
  output logic [ADDR_W-1:0] dn_awaddr,
  output logic [3:0]        dn_awlen,
  output logic [2:0]        dn_awsize,
  output logic [1:0]        dn_awburst
);

  logic [ID_W-1:0]   out_id;
  logic [OUT_W-1:0]  out_cnt;
  logic [3:0]        pieces_left;
  logic [3:0]        tail_len;
  logic [ADDR_W-1:0] step;
  logic              id_ok;
  logic              accept;
  logic              piece_go;

  assign id_ok      = (out_cnt == '0) || (up_awid == out_id);
  assign up_awready = !dn_awvalid && !q_full && id_ok;
  assign accept     = up_awvalid && up_awready;
  assign q_push     = accept;
  assign piece_go   = dn_awvalid && dn_awready;

  // Control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_awvalid <= 1'b0;
      out_cnt    <= '0;
    end else begin
      if (accept)                                dn_awvalid <= 1'b1;
      else if (piece_go && pieces_left == 4'd0)  dn_awvalid <= 1'b0;
      unique case ({accept, resp_done})
        2'b10:   out_cnt <= out_cnt + OUT_W'(1);
        2'b01:   out_cnt <= out_cnt - OUT_W'(1);
        default: ;
      endcase
    end
  end

  // Datapath registers, loaded on accept and advanced per issued piece
  always_ff @(posedge clk) begin
    if (accept) begin
      out_id      <= up_awid;
      dn_awid     <= up_awid;
      dn_awaddr   <= up_awaddr;
      dn_awsize   <= up_awsize;
      dn_awburst  <= up_awburst;
      pieces_left <= up_awlen[7:4];
      tail_len    <= up_awlen[3:0];
      dn_awlen    <= (up_awlen[7:4] != 4'd0) ? 4'hF : up_awlen[3:0];
      step        <= (up_awburst == BURST_INCR) ? (ADDR_W'(PIECE_BEATS) << up_awsize) : '0;
    end else if (piece_go && pieces_left != 4'd0) begin
      pieces_left <= pieces_left - 4'd1;
      dn_awaddr   <= dn_awaddr + step;
      dn_awlen    <= (pieces_left == 4'd1) ? tail_len : 4'hF;
    end
  end

  // R3: downstream address held until taken
  a_r3_aw_hold: assert property (@(posedge clk) disable iff (rst)
    dn_awvalid && !dn_awready |=> dn_awvalid && $stable(dn_awaddr)
                                  && $stable(dn_awlen) && $stable(dn_awid));

  // R6: an upstream response is only returned for an outstanding burst
  a_r6_no_spurious_b: assert property (@(posedge clk) disable iff (rst)
    resp_done |-> out_cnt != '0);

endmodule

// File: rtl/axi_split_w.sv
module axi_split_w #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                q_empty,
  input  logic [ID_W-1:0]     q_id,
  input  logic [7:0]          q_len,
  output logic                q_pop,
  input  logic                up_wvalid,
  output logic                up_wready,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_wstrb,
  input  logic                up_wlast,
  output logic                dn_wvalid,
  input  logic                dn_wready,
  output logic [ID_W-1:0]     dn_wid,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_wstrb,
  output logic                dn_wlast
);

  logic [7:0] beat;
  logic       burst_end;
  logic       piece_end;
  logic       xfer;

  assign burst_end = (beat == q_len);
  assign piece_end = (&beat[3:0]) || burst_end;

  // Beats pass through combinationally; a burst is open once its entry is queued
  assign dn_wvalid = up_wvalid && !q_empty;
  assign up_wready = dn_wready && !q_empty;
  assign dn_wid    = q_id;
  assign dn_wdata  = up_wdata;
  assign dn_wstrb  = up_wstrb;
  assign dn_wlast  = piece_end;
  assign xfer      = dn_wvalid && dn_wready;
  assign q_pop     = xfer && burst_end;

  always_ff @(posedge clk) begin
    if (rst)       beat <= '0;
    else if (xfer) beat <= burst_end ? 8'd0 : beat + 8'd1;
  end

  // R5: the master's last-beat flag agrees with the queued burst length
  a_r5_wlast_align: assert property (@(posedge clk) disable iff (rst)
    xfer |-> (up_wlast == burst_end));

endmodule

// File: rtl/axi_split_b.sv
module axi_split_b
  import axi_split_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            q_empty,
  input  logic [ID_W-1:0] q_id,
  input  logic [3:0]      q_last,
  output logic            q_pop,
  input  logic            dn_bvalid,
  output logic            dn_bready,
  input  logic [ID_W-1:0] dn_bid,
  input  logic [1:0]      dn_bresp,
  output logic            up_bvalid,
  input  logic            up_bready,
  output logic [ID_W-1:0] up_bid,
  output logic [1:0]      up_bresp
);

  logic [3:0] piece;
  logic [1:0] acc;
  logic [1:0] merged;
  logic       rx;
  logic       fin;

  assign dn_bready = !q_empty && !up_bvalid;
  assign rx        = dn_bvalid && dn_bready;
  assign fin       = rx && (piece == q_last);
  assign q_pop     = fin;
  assign merged    = resp_worse(acc, dn_bresp);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_bvalid <= 1'b0;
      piece     <= '0;
      acc       <= RESP_OKAY;
    end else begin
      if (up_bvalid && up_bready) up_bvalid <= 1'b0;
      if (rx) begin
        if (fin) begin
          up_bvalid <= 1'b1;
          piece     <= '0;
          acc       <= RESP_OKAY;
        end else begin
          piece     <= piece + 4'd1;
          acc       <= merged;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fin) begin
      up_bid   <= q_id;
      up_bresp <= merged;
    end
  end

  // R8: upstream response held until taken
  a_r8_b_hold: assert property (@(posedge clk) disable iff (rst)
    up_bvalid && !up_bready |=> up_bvalid && $stable(up_bresp) && $stable(up_bid));

  // R12: in-order responses carry the ID of the burst being merged
  a_r12_bid_match: assert property (@(posedge clk) disable iff (rst)
    rx |-> dn_bid == q_id);

endmodule

// File: rtl/axi_wr_burst_split.sv
module axi_wr_burst_split #(
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 4,
  parameter int DATA_W      = 64,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                up_awvalid,
  output logic                up_awready,
  input  logic [ID_W-1:0]     up_awid,
  input  logic [ADDR_W-1:0]   up_awaddr,
  input  logic [7:0]          up_awlen,
  input  logic [2:0]          up_awsize,
  input  logic [1:0]          up_awburst,
  input  logic                up_wvalid,
  output logic                up_wready,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_wstrb,
  input  logic                up_wlast,
  output logic                up_bvalid,
  input  logic                up_bready,
  output logic [ID_W-1:0]     up_bid,
  output logic [1:0]          up_bresp,
  output logic                dn_awvalid,
  input  logic                dn_awready,
  output logic [ID_W-1:0]     dn_awid,
  output logic [ADDR_W-1:0]   dn_awaddr,
  output logic [3:0]          dn_awlen,
  output logic [2:0]          dn_awsize,
  output logic [1:0]          dn_awburst,
  output logic                dn_wvalid,
  input  logic                dn_wready,
  output logic [ID_W-1:0]     dn_wid,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_wstrb,
  output logic                dn_wlast,
  input  logic                dn_bvalid,
  output logic                dn_bready,
  input  logic [ID_W-1:0]     dn_bid,
  input  logic [1:0]          dn_bresp
);

  localparam int WQ_W  = ID_W + 8;
  localparam int BQ_W  = ID_W + 4;
  localparam int OUT_W = $clog2(QUEUE_DEPTH + 2) + 1;

  logic            q_push;
  logic            q_full;
  logic            resp_done;
  logic            wq_full, wq_empty, wq_pop;
  logic            bq_full, bq_empty, bq_pop;
  logic [WQ_W-1:0] wq_dout;
  logic [BQ_W-1:0] bq_dout;
  logic [ID_W-1:0] wq_id, bq_id;
  logic [7:0]      wq_len;
  logic [3:0]      bq_last;

  assign q_full    = wq_full || bq_full;
  assign resp_done = up_bvalid && up_bready;
  assign {wq_id, wq_len}  = wq_dout;
  assign {bq_id, bq_last} = bq_dout;

  axi_split_aw #(.ADDR_W(ADDR_W), .ID_W(ID_W), .OUT_W(OUT_W)) u_aw (
    .clk(clk), .rst(rst),
    .up_awvalid(up_awvalid), .up_awready(up_awready), .up_awid(up_awid),
    .up_awaddr(up_awaddr), .up_awlen(up_awlen), .up_awsize(up_awsize),
    .up_awburst(up_awburst),
    .q_full(q_full), .q_push(q_push), .resp_done(resp_done),
    .dn_awvalid(dn_awvalid), .dn_awready(dn_awready), .dn_awid(dn_awid),
    .dn_awaddr(dn_awaddr), .dn_awlen(dn_awlen), .dn_awsize(dn_awsize),
    .dn_awburst(dn_awburst)
  );

  // Burst ID and total length for the data path
  axi_split_fifo #(.WIDTH(WQ_W), .DEPTH(QUEUE_DEPTH)) u_wq (
    .clk(clk), .rst(rst),
    .push(q_push), .din({up_awid, up_awlen}), .full(wq_full),
    .pop(wq_pop), .dout(wq_dout), .empty(wq_empty)
  );

  // Burst ID and index of the final piece for the response path
  axi_split_fifo #(.WIDTH(BQ_W), .DEPTH(QUEUE_DEPTH)) u_bq (
    .clk(clk), .rst(rst),
    .push(q_push), .din({up_awid, up_awlen[7:4]}), .full(bq_full),
    .pop(bq_pop), .dout(bq_dout), .empty(bq_empty)
  );

  axi_split_w #(.DATA_W(DATA_W), .ID_W(ID_W)) u_w (
    .clk(clk), .rst(rst),
    .q_empty(wq_empty), .q_id(wq_id), .q_len(wq_len), .q_pop(wq_pop),
    .up_wvalid(up_wvalid), .up_wready(up_wready), .up_wdata(up_wdata),
    .up_wstrb(up_wstrb), .up_wlast(up_wlast),
    .dn_wvalid(dn_wvalid), .dn_wready(dn_wready), .dn_wid(dn_wid),
    .dn_wdata(dn_wdata), .dn_wstrb(dn_wstrb), .dn_wlast(dn_wlast)
  );

  axi_split_b #(.ID_W(ID_W)) u_b (
    .clk(clk), .rst(rst),
    .q_empty(bq_empty), .q_id(bq_id), .q_last(bq_last), .q_pop(bq_pop),
    .dn_bvalid(dn_bvalid), .dn_bready(dn_bready), .dn_bid(dn_bid),
    .dn_bresp(dn_bresp),
    .up_bvalid(up_bvalid), .up_bready(up_bready), .up_bid(up_bid),
    .up_bresp(up_bresp)
  );

endmodule

// File: tb/axi_wr_burst_split_test.sv
module axi_wr_burst_split_test;

  localparam int ADDR_W = 32;
  localparam int ID_W   = 2;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int NTX    = 400;
  localparam int NPC    = 3200;
  localparam int LIMIT  = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst;
  logic                up_awvalid, up_awready;
  logic [ID_W-1:0]     up_awid;
  logic [ADDR_W-1:0]   up_awaddr;
  logic [7:0]          up_awlen;
  logic [2:0]          up_awsize;
  logic [1:0]          up_awburst;
  logic                up_wvalid, up_wready;
  logic [DATA_W-1:0]   up_wdata;
  logic [DATA_W/8-1:0] up_wstrb;
  logic                up_wlast;
  logic                up_bvalid, up_bready;
  logic [ID_W-1:0]     up_bid;
  logic [1:0]          up_bresp;
  logic                dn_awvalid, dn_awready;
  logic [ID_W-1:0]     dn_awid;
  logic [ADDR_W-1:0]   dn_awaddr;
  logic [3:0]          dn_awlen;
  logic [2:0]          dn_awsize;
  logic [1:0]          dn_awburst;
  logic                dn_wvalid, dn_wready;
  logic [ID_W-1:0]     dn_wid;
  logic [DATA_W-1:0]   dn_wdata;
  logic [DATA_W/8-1:0] dn_wstrb;
  logic                dn_wlast;
  logic                dn_bvalid, dn_bready;
  logic [ID_W-1:0]     dn_bid;
  logic [1:0]          dn_bresp;

  axi_wr_burst_split #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .QUEUE_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst),
    .up_awvalid(up_awvalid), .up_awready(up_awready), .up_awid(up_awid),
    .up_awaddr(up_awaddr), .up_awlen(up_awlen), .up_awsize(up_awsize), .up_awburst(up_awburst),
    .up_wvalid(up_wvalid), .up_wready(up_wready), .up_wdata(up_wdata),
    .up_wstrb(up_wstrb), .up_wlast(up_wlast),
    .up_bvalid(up_bvalid), .up_bready(up_bready), .up_bid(up_bid), .up_bresp(up_bresp),
    .dn_awvalid(dn_awvalid), .dn_awready(dn_awready), .dn_awid(dn_awid),
    .dn_awaddr(dn_awaddr), .dn_awlen(dn_awlen), .dn_awsize(dn_awsize), .dn_awburst(dn_awburst),
    .dn_wvalid(dn_wvalid), .dn_wready(dn_wready), .dn_wid(dn_wid),
    .dn_wdata(dn_wdata), .dn_wstrb(dn_wstrb), .dn_wlast(dn_wlast),
    .dn_bvalid(dn_bvalid), .dn_bready(dn_bready), .dn_bid(dn_bid), .dn_bresp(dn_bresp)
  );

  int tx_len[NTX], tx_id[NTX], tx_size[NTX], tx_addr[NTX], piece_base[NTX];
  int piece_tx[NPC];
  int n_tx, n0, n_pieces;
  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Injected downstream status for global piece g
  function automatic int inj(input int g);
    if (g % 11 == 5) return 3;
    if (g % 7 == 3)  return 2;
    if (g % 13 == 6) return 1;
    return 0;
  endfunction

  function automatic int sev(input int r);
    return (r == 3) ? 2 : (r == 2) ? 1 : 0;
  endfunction

  function automatic int expect_resp(input int k);
    int worst = 0;
    for (int p = 0; p <= (tx_len[k] >> 4); p++)
      if (sev(inj(piece_base[k] + p)) > worst) worst = sev(inj(piece_base[k] + p));
    return (worst == 2) ? 3 : (worst == 1) ? 2 : 0;
  endfunction

  function automatic logic [31:0] pat(input int k, input int b);
    return 32'(k * 1000 + b) ^ 32'hA5A50000;
  endfunction

  initial begin
    int aw_acc = 0, rk = 0, rp = 0, aw_pieces = 0;
    int wk = 0, wb = 0, w_pieces = 0, w_tx = 0, w_beat = 0;
    int b_iss = 0, rb_acc = 0, bk = 0, cyc = 0, mode = 0;
    bit w_ahead = 0;
    bit aw_fire, lw_fire, mb_fire;
    bit g0, g1, g2, g3, g4, g5;
    bit aw_hold = 0, b_hold = 0;
    int held_addr = 0, held_bresp = 0, held_bid = 0;

    // Batch 0: every length 1..256 beats; batch 1: descending lengths, same-ID runs
    n_tx = 0; n_pieces = 0;
    for (int k = 0; k < 256; k++) begin
      tx_len[n_tx] = k; tx_id[n_tx] = (k / 2) % 4; tx_size[n_tx] = k % 3;
      tx_addr[n_tx] = k * 4096; n_tx++;
    end
    n0 = n_tx;
    for (int j = 0; j < 86; j++) begin
      tx_len[n_tx] = 255 - 3 * j; tx_id[n_tx] = (j / 3) % 4; tx_size[n_tx] = (j + 1) % 3;
      tx_addr[n_tx] = (256 + j) * 4096 + (j % 4) * 64; n_tx++;
    end
    for (int k = 0; k < n_tx; k++) begin
      piece_base[k] = n_pieces;
      for (int p = 0; p <= (tx_len[k] >> 4); p++) begin
        piece_tx[n_pieces] = k; n_pieces++;
      end
    end

    up_awvalid = 0; up_awid = '0; up_awaddr = '0; up_awlen = '0; up_awsize = '0; up_awburst = 2'b01;
    up_wvalid = 1; up_wdata = '0; up_wstrb = '0; up_wlast = 0;
    up_bready = 0; dn_awready = 1; dn_wready = 1;
    dn_bvalid = 0; dn_bid = '0; dn_bresp = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 dn_awvalid in reset", dn_awvalid, 0);
    check("R11 up_bvalid in reset", up_bvalid, 0);
    check("R11 up_wready in reset", up_wready, 0);
    check("R11 dn_wvalid in reset", dn_wvalid, 0);
    up_wvalid = 0;
    rst = 0;

    while (bk < n_tx && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      aw_fire = 0; lw_fire = 0; mb_fire = 0;

      if (aw_hold) begin
        check("R3 dn_awvalid held", dn_awvalid, 1);
        check("R3 dn_awaddr held", dn_awaddr, held_addr);
      end
      aw_hold = dn_awvalid && !dn_awready;
      held_addr = int'(dn_awaddr);
      if (b_hold) begin
        check("R8 up_bvalid held", up_bvalid, 1);
        check("R8 up_bresp held", up_bresp, held_bresp);
        check("R8 up_bid held", up_bid, held_bid);
      end
      b_hold = up_bvalid && !up_bready;
      held_bresp = int'(up_bresp); held_bid = int'(up_bid);

      // R9: a different ID waits while an earlier burst awaits its response
      if (up_awvalid && aw_acc > bk && tx_id[aw_acc] != tx_id[aw_acc - 1])
        check("R9 throttle", up_awready, 0);

      if (up_awvalid && up_awready) begin aw_acc++; aw_fire = 1; end

      if (dn_awvalid && dn_awready) begin
        check("R1 piece id", dn_awid, tx_id[rk]);
        check("R1 piece len", dn_awlen, (rp < (tx_len[rk] >> 4)) ? 15 : (tx_len[rk] & 15));
        check("R1 piece size", dn_awsize, tx_size[rk]);
        check("R1 piece burst", dn_awburst, 1);
        check("R2 piece addr", dn_awaddr, tx_addr[rk] + rp * (16 << tx_size[rk]));
        aw_pieces++;
        if (rp == (tx_len[rk] >> 4)) begin rk++; rp = 0; end else rp++;
      end

      if (dn_wvalid && dn_wready) begin
        check("R4 wid", dn_wid, tx_id[wk]);
        check("R4 wdata", dn_wdata, pat(wk, wb));
        check("R4 wstrb", dn_wstrb, (wk + wb) & 15);
        check("R5 wlast", dn_wlast, ((wb % 16) == 15 || wb == tx_len[wk]) ? 1 : 0);
        if ((wb % 16) == 15 || wb == tx_len[wk]) w_pieces++;
        if (wb == tx_len[wk]) begin wk++; wb = 0; end else wb++;
      end

      if (up_wvalid && up_wready) begin
        if (w_tx > bk) w_ahead = 1;
        lw_fire = 1;
        if (w_beat == tx_len[w_tx]) begin w_tx++; w_beat = 0; end else w_beat++;
      end

      if (dn_bvalid && dn_bready) begin rb_acc++; mb_fire = 1; end

      if (up_bvalid && up_bready) begin
        check("R6 bid", up_bid, tx_id[bk]);
        check("R7 merged bresp", up_bresp, expect_resp(bk));
        check("R6 all pieces answered", (rb_acc >= piece_base[bk] + (tx_len[bk] >> 4) + 1) ? 1 : 0, 1);
        bk++;
      end

      @(posedge clk);
      #1;
      mode = (aw_acc >= n0) ? 1 : 0;
      g0 = (mode == 0) || (cyc % 4 != 1);
      g1 = (mode == 0) || (cyc % 5 != 3);
      g2 = (mode == 0) || (cyc % 3 != 0);
      g3 = (mode == 0) || ((cyc % 7 != 2) && (cyc % 7 != 5));
      g4 = (mode == 0) || (cyc % 3 != 1);
      g5 = (mode == 0) || (cyc % 4 != 0);

      if (aw_fire) up_awvalid = 0;
      if (!up_awvalid && aw_acc < n_tx && g0) begin
        up_awvalid = 1;
        up_awid    = ID_W'(tx_id[aw_acc]);
        up_awaddr  = ADDR_W'(tx_addr[aw_acc]);
        up_awlen   = 8'(tx_len[aw_acc]);
        up_awsize  = 3'(tx_size[aw_acc]);
        up_awburst = 2'b01;
      end
      if (lw_fire) up_wvalid = 0;
      if (!up_wvalid && w_tx < n_tx && g1) begin
        up_wvalid = 1;
        up_wdata  = pat(w_tx, w_beat);
        up_wstrb  = 4'((w_tx + w_beat) & 15);
        up_wlast  = (w_beat == tx_len[w_tx]);
      end
      dn_awready = g2;
      dn_wready  = g3;
      up_bready  = g4;
      if (mb_fire) dn_bvalid = 0;
      if (!dn_bvalid && b_iss < aw_pieces && b_iss < w_pieces && g5) begin
        dn_bvalid = 1;
        dn_bid    = ID_W'(tx_id[piece_tx[b_iss]]);
        dn_bresp  = 2'(inj(b_iss));
        b_iss++;
      end
    end

    if (cyc >= LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", bk, n_tx);
    end else begin
      check("R6 one response per burst", bk, n_tx);
      check("R1 total pieces issued", aw_pieces, n_pieces);
      check("R5 total pieces closed", w_pieces, n_pieces);
      check("R10 data ran ahead of responses", w_ahead, 1);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        check("R6 no extra response", up_bvalid, 0);
        check("R1 no extra piece", dn_awvalid, 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule